// File: doc/BRIEF.md
# Graphics Port Write-Path Mode Controller

This block decides how each memory write bound for a graphics master is carried. It chooses between a fast-write path at quad rate (16 bytes per clock), a fast-write path at double rate (8 bytes per clock), and the standard PCI-style path. Fast writes are used only when two separate enables are both set and a valid data rate has been locked in at initialization. The controller also sequences the data beats of each fast write, producing a byte offset, a beat size and byte enables for every clock.

Requests come from an upstream queue through a valid/ready handshake. Each request carries a length in bytes, and the block rounds it up to whole 64-byte blocks. The target may throttle only at the first clock of each four-clock group. A request routed to the standard path is handed on with a one-cycle start pulse. A fast write ends with a done pulse. The data-rate field is captured once, on an init strobe. Any later attempt to change it, or a captured value that does not have exactly one bit set, raises a sticky error and forces every write onto the standard path.

Top module: `gfx_wr_mode_ctrl`

## Requirements
- R1: A request takes the fast-write path only when `cap_en` and `fw_en` are both 1, the rate is locked, there is no error, and the locked rate has bit 2 or bit 1 set. Any other request gets `std_start`=1 with `std_len` equal to its length in the cycle after acceptance, and produces no beats.
- R2: `fw_status` is 0 during and after reset. In every later cycle it shows the value `cap_en` had on the previous clock edge.
- R3: The first `init_done` pulse after reset latches `rate_in`. A latched value of 3'b100 gives 16-byte beats, with four beats per 64-byte block.
- R4: A latched value of 3'b010 gives 8-byte beats, with eight beats per block. Byte-enable bits 15..8 stay 0.
- R5: A latched value of 3'b001 sends every write down the standard path, even when both enables are set. It does not raise `cfg_err`.
- R6: A latched value with zero bits set, or with more than one bit set, sets `cfg_err` in the cycle after `init_done`. All writes then take the standard path.
- R7: Once the rate is locked, a `rate_wr` pulse or a second `init_done` pulse sets `cfg_err`. The flag stays set until reset and the locked rate does not change.
- R8: At the first clock of each four-clock group, a beat is issued only if `tgt_blk_ready` is 1. On the other three clocks of the group, a beat is issued every clock whatever `tgt_blk_ready` is.
- R9: In a beat at offset `off`, bit i of `fw_be` is 1 exactly when i < beat size and off+i < length. The transfer pads with all-zero beats up to a 64-byte boundary, and a length of 0 becomes one block with every enable off.
- R10: `fw_done` pulses for one cycle right after the last beat of a fast write. `req_ready` is 0 while a fast write is in progress and 1 otherwise.
- R11: `fw_beat_off` starts at 0 for each request and grows by the beat size with each beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Fast-write capability enable |
| fw_en | input | 1 | Fast-write enable |
| rate_in | input | 3 | Data-rate field (bit2 quad, bit1 double, bit0 standard) |
| rate_wr | input | 1 | Software write to the data-rate field |
| init_done | input | 1 | Initialization strobe that latches the rate |
| fw_status | output | 1 | Advertised fast-write support |
| cfg_err | output | 1 | Sticky rate configuration error |
| req_valid | input | 1 | Request valid |
| req_len | input | LEN_W | Request length in bytes |
| req_ready | output | 1 | Request accepted when high with req_valid |
| std_start | output | 1 | Request handed to the standard path |
| std_len | output | LEN_W | Length of the standard-path request |
| tgt_blk_ready | input | 1 | Target ready for the next four-clock group |
| fw_beat_valid | output | 1 | Fast-write data beat this clock |
| fw_beat_off | output | LEN_W+1 | Byte offset of the beat |
| fw_beat_bytes | output | log2(QUAD_BYTES)+1 | Bytes per beat (16 or 8) |
| fw_be | output | QUAD_BYTES | Byte enables of the beat |
| fw_done | output | 1 | Last beat of a fast write finished |

## Verification
The hardest case to reach from the ports is a target that stalls at a group boundary while the same `tgt_blk_ready` level also appears in the middle of a group, where it must be ignored. Reaching it takes long, padded transfers at both rates. The bench drives `tgt_blk_ready` from a pseudo-random pattern during these transfers, and the monitor tracks the expected position within the four-clock group on its own. It flags any stall that happens mid-group and any missing beat at a boundary. The lock rules are reached by resetting the block several times and latching a different rate value each time.

// File: rtl/gwm_pkg.sv
package gwm_pkg;
  typedef enum logic [1:0] {
    PATH_STD  = 2'd0,
    PATH_FW2X = 2'd1,
    PATH_FW4X = 2'd2
  } gwm_path_e;
endpackage

// File: rtl/gwm_rate_cfg.sv
module gwm_rate_cfg
  import gwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_en,
  input  logic      fw_en,
  input  logic [2:0] rate_in,
  input  logic      rate_wr,
  input  logic      init_done,
  output gwm_path_e path,
  output logic      cfg_err,
  output logic      fw_status
);
  logic locked_q, locked_d;
  logic quad_q, quad_d, dual_q, dual_d;
  logic err_q, err_d;
  logic stat_q;
  logic onehot_in;
  logic latch_en;

  assign onehot_in = (rate_in != 3'b000) && ((rate_in & (rate_in - 3'd1)) == 3'b000);
  assign latch_en  = !locked_q && init_done;

  always_comb begin
    locked_d = locked_q;
    quad_d   = quad_q;
    dual_d   = dual_q;
    err_d    = err_q;
    if (latch_en) begin
      locked_d = 1'b1;
      quad_d   = rate_in[2];
      dual_d   = rate_in[1];
      if (!onehot_in) err_d = 1'b1;
    end else if (locked_q && (init_done || rate_wr)) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      quad_q   <= 1'b0;
      dual_q   <= 1'b0;
      err_q    <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      if (latch_en) begin
        quad_q <= quad_d;
        dual_q <= dual_d;
      end
      locked_q <= locked_d;
      err_q    <= err_d;
      stat_q   <= cap_en;
    end
  end

  always_comb begin
    path = PATH_STD;
    if (locked_q && !err_q && cap_en && fw_en) begin
      if (quad_q)      path = PATH_FW4X;
      else if (dual_q) path = PATH_FW2X;
    end
  end

  assign cfg_err   = err_q;
  assign fw_status = stat_q;

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_q) |-> ($stable(quad_q) && $stable(dual_q))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q); // R7
endmodule

// File: rtl/gwm_be_gen.sv
module gwm_be_gen #(
  parameter int BE_W  = 16,
  parameter int OFF_W = 13,
  parameter int LEN_W = 12
) (
  input  logic             valid,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] size,
  input  logic [LEN_W-1:0] len,
  output logic [BE_W-1:0]  be
);
  localparam int SUM_W = OFF_W + 1;

  for (genvar gi = 0; gi < BE_W; gi++) begin : g_lane
    logic [SUM_W-1:0] pos;
    assign pos    = {1'b0, off} + SUM_W'(gi);
    assign be[gi] = valid && (OFF_W'(gi) < size) && (pos < SUM_W'(len));
  end
endmodule

// File: rtl/gwm_beat_seq.sv
module gwm_beat_seq
  import gwm_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int BLK_BYTES  = 64,
  parameter int QUAD_BYTES = 16,
  parameter int DUAL_BYTES = 8,
  parameter int THR_CLKS   = 4,
  localparam int OFF_W     = LEN_W + 1,
  localparam int SZ_W      = $clog2(QUAD_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gwm_path_e        path,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             std_start,
  output logic [LEN_W-1:0] std_len,
  input  logic             tgt_blk_ready,
  output logic             beat_valid,
  output logic [OFF_W-1:0] beat_off,
  output logic [OFF_W-1:0] beat_size,
  output logic [SZ_W-1:0]  beat_bytes,
  output logic [LEN_W-1:0] cur_len,
  output logic             done
);
  localparam int GRP_W  = (THR_CLKS > 1) ? $clog2(THR_CLKS) : 1;
  localparam int BLK_SH = $clog2(BLK_BYTES);

  logic             busy_q, busy_d;
  logic             quad_q, quad_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [OFF_W-1:0] end_q, end_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             done_q, done_d;
  logic             std_q, std_d;
  logic [LEN_W-1:0] slen_q;

  logic             accept, is_fw, go, last;
  logic             ld_en, seq_en, std_en;
  logic [OFF_W-1:0] size, ext, end_calc;

  assign is_fw    = (path != PATH_STD);
  assign accept   = req_valid && !busy_q;
  assign ld_en    = accept && is_fw;
  assign std_en   = accept && !is_fw;
  assign size     = quad_q ? OFF_W'(QUAD_BYTES) : OFF_W'(DUAL_BYTES);
  assign go       = busy_q && ((grp_q != '0) || tgt_blk_ready);
  assign last     = go && ((off_q + size) == end_q);
  assign seq_en   = ld_en || go;
  assign ext      = OFF_W'(req_len) + OFF_W'(BLK_BYTES - 1);
  assign end_calc = (ext == '0 || (ext & ~OFF_W'(BLK_BYTES - 1)) == '0)
                    ? OFF_W'(BLK_BYTES) : (ext & ~OFF_W'(BLK_BYTES - 1));

  always_comb begin
    busy_d = busy_q;
    quad_d = quad_q;
    off_d  = off_q;
    end_d  = end_q;
    len_d  = len_q;
    grp_d  = grp_q;
    done_d = 1'b0;
    std_d  = 1'b0;
    if (ld_en) begin
      busy_d = 1'b1;
      quad_d = (path == PATH_FW4X);
      off_d  = '0;
      end_d  = end_calc;
      len_d  = req_len;
      grp_d  = '0;
    end else if (std_en) begin
      std_d  = 1'b1;
    end else if (go) begin
      off_d  = off_q + size;
      grp_d  = (grp_q == GRP_W'(THR_CLKS - 1)) ? '0 : grp_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      quad_q <= 1'b0;
      off_q  <= '0;
      end_q  <= '0;
      len_q  <= '0;
      grp_q  <= '0;
      done_q <= 1'b0;
      std_q  <= 1'b0;
      slen_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      std_q  <= std_d;
      if (ld_en) begin
        quad_q <= quad_d;
        end_q  <= end_d;
        len_q  <= len_d;
      end
      if (seq_en) begin
        off_q <= off_d;
        grp_q <= grp_d;
      end
      if (std_en) slen_q <= req_len;
    end
  end

  assign req_ready  = !busy_q;
  assign std_start  = std_q;
  assign std_len    = slen_q;
  assign beat_valid = go;
  assign beat_off   = off_q;
  assign beat_size  = size;
  assign beat_bytes = quad_q ? SZ_W'(QUAD_BYTES) : SZ_W'(DUAL_BYTES);
  assign cur_len    = len_q;
  assign done       = done_q;

  AST_STALL_ONLY_AT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !beat_valid) |-> (grp_q == '0)); // R8
  AST_DONE_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (off_q[BLK_SH-1:0] == '0)); // R9
  AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (off_q < end_q)); // R11
  AST_NO_STD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    std_q |-> !busy_q); // R1
endmodule

// File: rtl/gfx_wr_mode_ctrl.sv
module gfx_wr_mode_ctrl
  import gwm_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int BLK_BYTES  = 64,
  parameter int QUAD_BYTES = 16,
  parameter int DUAL_BYTES = 8,
  parameter int THR_CLKS   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic                         fw_en,
  input  logic [2:0]                   rate_in,
  input  logic                         rate_wr,
  input  logic                         init_done,
  output logic                         fw_status,
  output logic                         cfg_err,
  input  logic                         req_valid,
  input  logic [LEN_W-1:0]             req_len,
  output logic                         req_ready,
  output logic                         std_start,
  output logic [LEN_W-1:0]             std_len,
  input  logic                         tgt_blk_ready,
  output logic                         fw_beat_valid,
  output logic [LEN_W:0]               fw_beat_off,
  output logic [$clog2(QUAD_BYTES):0]  fw_beat_bytes,
  output logic [QUAD_BYTES-1:0]        fw_be,
  output logic                         fw_done
);
  localparam int OFF_W = LEN_W + 1;

  gwm_path_e        path;
  logic [OFF_W-1:0] beat_size;
  logic [LEN_W-1:0] cur_len;

  gwm_rate_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .fw_en     (fw_en),
    .rate_in   (rate_in),
    .rate_wr   (rate_wr),
    .init_done (init_done),
    .path      (path),
    .cfg_err   (cfg_err),
    .fw_status (fw_status)
  );

  gwm_beat_seq #(
    .LEN_W      (LEN_W),
    .BLK_BYTES  (BLK_BYTES),
    .QUAD_BYTES (QUAD_BYTES),
    .DUAL_BYTES (DUAL_BYTES),
    .THR_CLKS   (THR_CLKS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .path          (path),
    .req_valid     (req_valid),
    .req_len       (req_len),
    .req_ready     (req_ready),
    .std_start     (std_start),
    .std_len       (std_len),
    .tgt_blk_ready (tgt_blk_ready),
    .beat_valid    (fw_beat_valid),
    .beat_off      (fw_beat_off),
    .beat_size     (beat_size),
    .beat_bytes    (fw_beat_bytes),
    .cur_len       (cur_len),
    .done          (fw_done)
  );

  gwm_be_gen #(
    .BE_W  (QUAD_BYTES),
    .OFF_W (OFF_W),
    .LEN_W (LEN_W)
  ) u_be (
    .valid (fw_beat_valid),
    .off   (fw_beat_off),
    .size  (beat_size),
    .len   (cur_len),
    .be    (fw_be)
  );

  AST_FW_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(cap_en && fw_en)); // R1
  AST_DUAL_UPPER_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_beat_valid && fw_beat_bytes == ($clog2(QUAD_BYTES)+1)'(DUAL_BYTES))
      |-> (fw_be[QUAD_BYTES-1:DUAL_BYTES] == '0)); // R4
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fw_done |-> $past(fw_beat_valid)); // R10
endmodule

// File: tb/tb_gfx_wr_mode_ctrl.sv
module tb_gfx_wr_mode_ctrl;
  localparam int LEN_W = 12;

  typedef struct {
    int           off;
    logic [15:0]  be;
    int           bytes;
    bit           last;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cap_en, fw_en, rate_wr, init_done, req_valid, tgt_blk_ready;
  logic [2:0] rate_in;
  logic [LEN_W-1:0] req_len;
  logic fw_status, cfg_err, req_ready, std_start, fw_beat_valid, fw_done;
  logic [LEN_W-1:0] std_len;
  logic [LEN_W:0] fw_beat_off;
  logic [4:0] fw_beat_bytes;
  logic [15:0] fw_be;

  int n_chk = 0;
  int n_fail = 0;
  beat_t exp_q[$];
  int  mon_grp;
  bit  pend_done;
  bit  thr_mode;
  logic [7:0] lfsr;

  bit b_locked, b_err;
  logic [2:0] b_rate;

  always #5 clk = ~clk;

  gfx_wr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fw_en(fw_en),
    .rate_in(rate_in), .rate_wr(rate_wr), .init_done(init_done),
    .fw_status(fw_status), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_len(req_len), .req_ready(req_ready), .std_start(std_start),
    .std_len(std_len), .tgt_blk_ready(tgt_blk_ready),
    .fw_beat_valid(fw_beat_valid), .fw_beat_off(fw_beat_off),
    .fw_beat_bytes(fw_beat_bytes), .fw_be(fw_be), .fw_done(fw_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // target throttle pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tgt_blk_ready <= thr_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) begin
        chk(fw_done === 1'b1, "R10 done pulse", fw_done, 1);
        pend_done = 1'b0;
      end else begin
        chk(fw_done === 1'b0, "R10 stray done", fw_done, 0);
      end
      if (exp_q.size() > 0) begin
        chk(req_ready === 1'b0, "R10 ready low while busy", req_ready, 0);
        if (fw_beat_valid === 1'b1) begin
          beat_t e;
          e = exp_q.pop_front();
          chk(mon_grp != 0 || tgt_blk_ready, "R8 beat at stalled boundary", 1, 0);
          chk(fw_beat_off == e.off, "R11 beat offset", fw_beat_off, e.off);
          chk(fw_be === e.be, "R9 byte enables", fw_be, e.be);
          chk(fw_beat_bytes == e.bytes, "R3/R4 beat size", fw_beat_bytes, e.bytes);
          mon_grp = (mon_grp + 1) % 4;
          if (e.last) pend_done = 1'b1;
        end else begin
          chk(mon_grp == 0 && !tgt_blk_ready, "R8 missing beat", 0, 1);
        end
      end else begin
        chk(fw_beat_valid !== 1'b1, "R1 unexpected beat", fw_beat_valid, 0);
      end
    end
  end

  function automatic bit exp_fw();
    return b_locked && !b_err && cap_en && fw_en && (b_rate[2] || b_rate[1]);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    pend_done = 1'b0;
    b_locked = 1'b0; b_err = 1'b0; b_rate = 3'b000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(fw_status === 1'b0, "R2 status after reset", fw_status, 0);
    chk(cfg_err === 1'b0, "R6 err after reset", cfg_err, 0);
    chk(req_ready === 1'b1, "R10 ready after reset", req_ready, 1);
    chk(fw_beat_valid === 1'b0, "R10 no beat after reset", fw_beat_valid, 0);
  endtask

  task automatic pulse_init(input logic [2:0] r);
    @(posedge clk); #1;
    rate_in = r; init_done = 1'b1;
    if (!b_locked) begin
      b_locked = 1'b1; b_rate = r;
      if (!(r == 3'b001 || r == 3'b010 || r == 3'b100)) b_err = 1'b1;
    end else b_err = 1'b1;
    @(posedge clk); #1 init_done = 1'b0;
    @(negedge clk);
    chk(cfg_err === b_err, "R6/R7 err after init", cfg_err, b_err);
  endtask

  task automatic pulse_wr(input logic [2:0] r);
    @(posedge clk); #1;
    rate_in = r; rate_wr = 1'b1;
    if (b_locked) b_err = 1'b1;
    @(posedge clk); #1 rate_wr = 1'b0;
    @(negedge clk);
    chk(cfg_err === b_err, "R7 err after rate write", cfg_err, b_err);
  endtask

  task automatic send(input int len, input string tag);
    bit fw;
    int sz, endb;
    fw = exp_fw();
    sz = b_rate[2] ? 16 : 8;
    @(posedge clk); #1;
    req_valid = 1'b1; req_len = LEN_W'(len);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (fw) begin
      endb = ((len + 63) / 64) * 64;
      if (endb == 0) endb = 64;
      mon_grp = 0;
      for (int o = 0; o < endb; o += sz) begin
        beat_t b;
        b.off = o; b.bytes = sz; b.last = (o + sz == endb);
        for (int i = 0; i < 16; i++) b.be[i] = (i < sz) && (o + i < len);
        exp_q.push_back(b);
      end
      while (exp_q.size() != 0 || pend_done) @(posedge clk);
      #1;
    end else begin
      @(negedge clk);
      chk(std_start === 1'b1, {tag, " std_start"}, std_start, 1);
      chk(std_len == LEN_W'(len), {tag, " std_len"}, std_len, len);
      chk(req_ready === 1'b1, {tag, " ready on std"}, req_ready, 1);
      @(negedge clk);
      chk(std_start === 1'b0, {tag, " std_start single"}, std_start, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_en = 1'b0; fw_en = 1'b0; rate_in = 3'b000;
    rate_wr = 1'b0; init_done = 1'b0; req_valid = 1'b0; req_len = '0;
    thr_mode = 1'b0; lfsr = 8'h5a; tgt_blk_ready = 1'b1;
    mon_grp = 0; pend_done = 1'b0;

    // Quad-rate phase
    do_reset();
    cap_en = 1'b1; fw_en = 1'b1;
    send(64, "R1 unlocked");
    pulse_wr(3'b010);             // write before lock is ignored
    pulse_init(3'b100);           // R3
    cap_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(fw_status === 1'b0, "R2 status follows cap off", fw_status, 0);
    send(64, "R1 cap off");
    cap_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(fw_status === 1'b1, "R2 status follows cap on", fw_status, 1);
    fw_en = 1'b0;
    send(80, "R1 fw_en off");
    fw_en = 1'b1;
    send(64, "R3 quad block");
    send(100, "R9 padded");
    send(0, "R9 zero length");
    send(1, "R9 one byte");
    thr_mode = 1'b1;
    send(200, "R8 throttled quad");
    send(256, "R8 throttled quad long");
    thr_mode = 1'b0;
    pulse_wr(3'b010);             // R7
    send(64, "R7 after rate write");

    // Double-rate phase
    do_reset();
    pulse_init(3'b010);
    send(64, "R4 dual block");
    thr_mode = 1'b1;
    send(72, "R4 R8 dual throttled");
    send(130, "R9 dual padded");
    thr_mode = 1'b0;
    pulse_init(3'b100);           // R7 second init
    send(64, "R7 after second init");

    // Invalid rate values
    do_reset();
    pulse_init(3'b011);           // R6
    send(64, "R6 multi-bit rate");
    do_reset();
    pulse_init(3'b000);           // R6
    send(64, "R6 zero rate");

    // Standard rate selected
    do_reset();
    pulse_init(3'b001);           // R5
    chk(cfg_err === 1'b0, "R5 no error", cfg_err, 0);
    send(64, "R5 standard rate");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule